// File: doc/BRIEF.md
# UART Byte Buffering with DMA Ready and Interrupt Signalling

This block holds the transmit and receive byte stores of one UART channel and turns their fill levels into two active-low DMA request pins and one active-high interrupt. The CPU side writes bytes for transmission and reads received bytes. The serial side delivers received bytes with a one-cycle arrival strobe, and it takes bytes for transmission with a one-cycle taken strobe. A character-timeout pulse comes from the receive timing logic.

Two mode bits pick the behaviour. With buffering off, each direction holds a single byte. With buffering on, each direction is a 16-entry first-in first-out store, and the receive interrupt follows a programmable trigger level. Setting the DMA bit as well switches the ready pins to block-transfer semantics. The receive request then latches on at the trigger level or on a timeout and releases only when the store has drained. The transmit request stays asserted while any slot is free.

Top module: `uart_ready_irq`

## Requirements
- R1: After reset both stores are empty, `txrdy_n` is 0, `rxrdy_n` is 1 and `irq` equals `tx_irq_en`.
- R2: With `fifo_en`=0 the receive side holds one byte. `rxrdy_n` is 0 while that byte is held and 1 otherwise. A byte that arrives while one is held is discarded.
- R3: With `fifo_en`=0 the transmit side holds one byte. `txrdy_n` is 1 while that byte is held and 0 when the register is empty. A CPU write while the register is occupied is discarded.
- R4: With `fifo_en`=1 and `dma_mode`=0, `rxrdy_n` is 0 exactly while the receive store holds one or more bytes.
- R5: With `fifo_en`=1 and `dma_mode`=0, `txrdy_n` is 0 exactly while the transmit store is empty.
- R6: With `fifo_en`=1 and `dma_mode`=1, `rxrdy_n` falls in the same cycle that the receive fill reaches the trigger level. `rx_trig_sel` codes 0, 1, 2 and 3 select 1, 4, 8 and 14 entries. `rxrdy_n` then stays 0 while reads lower the fill, and returns to 1 only when the store is empty.
- R7: With `fifo_en`=1 and `dma_mode`=1, a `char_timeout` pulse with at least one byte stored drives `rxrdy_n` to 0 from the next cycle. A pulse with the store empty has no effect.
- R8: With `fifo_en`=1 and `dma_mode`=1, `txrdy_n` is 1 only when all 16 transmit entries are occupied.
- R9: `irq` is the OR of two terms. The first is `tx_irq_en` AND an empty transmit side. The second is `rx_irq_en` AND a receive condition. That condition is "one byte held" with buffering off, and "fill at or above the trigger level" with buffering on.
- R10: A write to a full transmit store is dropped, and byte order is kept. A CPU read of an empty receive store leaves `cpu_rdata` and the fill unchanged.
- R11: Any change of `fifo_en` empties both stores at the next clock edge and clears the DMA receive latch, which leaves `rxrdy_n`=1 and `txrdy_n`=0.
- R12: Bytes leave each store in arrival order. `cpu_rdata` is registered and shows the byte read one cycle after `cpu_rd`. `tx_data` always shows the oldest transmit byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_en | input | 1 | 1 = 16-entry stores, 0 = single holding registers |
| dma_mode | input | 1 | Block-transfer semantics for the ready pins |
| rx_trig_sel | input | 2 | Receive trigger code (1/4/8/14 entries) |
| tx_irq_en | input | 1 | Enables the transmit-empty interrupt term |
| rx_irq_en | input | 1 | Enables the receive interrupt term |
| cpu_wr | input | 1 | CPU write strobe into the transmit side |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rd | input | 1 | CPU read strobe from the receive side |
| cpu_rdata | output | 8 | Last byte read (registered) |
| rx_push | input | 1 | Receiver byte-arrival strobe |
| rx_data | input | 8 | Arriving byte |
| tx_pop | input | 1 | Transmitter byte-taken strobe |
| tx_data | output | 8 | Oldest transmit byte |
| tx_avail | output | 1 | Transmit side holds at least one byte |
| char_timeout | input | 1 | Character-timeout pulse |
| txrdy_n | output | 1 | Transmit DMA ready, active low |
| rxrdy_n | output | 1 | Receive DMA ready, active low |
| irq | output | 1 | Interrupt, active high |

## Verification
The bench walks every trigger code in DMA mode and reads the store down byte by byte. A design that computed the receive pin from the live level instead of a latch would release it as soon as the fill dropped below the trigger. It pulses the timeout with data present and with the store empty, so a latch that ignored the empty case would leave the pin stuck low over an empty store. It fills the transmit store to 16 and then writes a 17th byte, so a store that wrapped its pointer would overwrite the oldest byte or lose the full flag. It also toggles the buffer enable with data in both directions and reads an empty receive side, so stale data after a mode switch, or an underflowing count, would show up on the read port.

// File: rtl/uart_rdy_pkg.sv
package uart_rdy_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'd0,
        MODE_FIFO = 2'd1,
        MODE_DMA  = 2'd2
    } rdy_mode_e;

    typedef struct packed {
        logic push;
        logic pop;
        logic flush;
    } fifo_ctl_t;

    typedef struct packed {
        logic txrdy_n;
        logic rxrdy_n;
        logic irq;
    } pin_out_t;

    function automatic rdy_mode_e pick_mode(input logic en, input logic dma);
        if (!en)
            return MODE_HOLD;
        else if (dma)
            return MODE_DMA;
        else
            return MODE_FIFO;
    endfunction

    function automatic int unsigned trig_entries(input logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo
    import uart_rdy_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  fifo_ctl_t     ctl,
    input  logic          single,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          full;
    logic          empty;
    logic          push_ok;
    logic          pop_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        if (p == AW'(DEPTH - 1))
            return '0;
        else
            return p + AW'(1);
    endfunction

    assign empty   = (count == '0);
    assign full    = single ? !empty : (count == CW'(DEPTH));
    assign push_ok = ctl.push && !full && !ctl.flush;
    assign pop_ok  = ctl.pop && !empty && !ctl.flush;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok)
                wr_ptr <= bump(wr_ptr);
            if (pop_ok)
                rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/uart_rx_dma_hyst.sv
module uart_rx_dma_hyst
    import uart_rdy_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  fifo_ctl_t     ctl,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] trig,
    input  logic          timeout,
    output logic          active
);

    logic          push_ok;
    logic          pop_ok;
    logic [CW-1:0] level_nxt;
    logic          active_d;

    // Mirror of the store's acceptance rule in block mode (capacity DEPTH)
    assign push_ok = ctl.push && (count != CW'(DEPTH));
    assign pop_ok  = ctl.pop && (count != '0);

    always_comb begin
        level_nxt = count;
        if (push_ok && !pop_ok)
            level_nxt = count + CW'(1);
        else if (pop_ok && !push_ok)
            level_nxt = count - CW'(1);
    end

    always_comb begin
        if (!enable || ctl.flush || level_nxt == '0)
            active_d = 1'b0;
        else
            active_d = active || (level_nxt >= trig) || timeout;
    end

    always_ff @(posedge clk) begin
        if (rst)
            active <= 1'b0;
        else
            active <= active_d;
    end

endmodule

// File: rtl/uart_pin_map.sv
module uart_pin_map
    import uart_rdy_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  rdy_mode_e     mode,
    input  logic [CW-1:0] tx_cnt,
    input  logic [CW-1:0] rx_cnt,
    input  logic [CW-1:0] trig,
    input  logic          dma_act,
    input  logic          tx_irq_en,
    input  logic          rx_irq_en,
    output pin_out_t      pins
);

    logic tx_empty;
    logic rx_empty;
    logic rx_cond;

    assign tx_empty = (tx_cnt == '0);
    assign rx_empty = (rx_cnt == '0);

    always_comb begin
        case (mode)
            MODE_DMA: begin
                pins.txrdy_n = (tx_cnt == CW'(DEPTH));
                pins.rxrdy_n = !dma_act;
                rx_cond      = (rx_cnt >= trig);
            end
            MODE_FIFO: begin
                pins.txrdy_n = !tx_empty;
                pins.rxrdy_n = rx_empty;
                rx_cond      = (rx_cnt >= trig);
            end
            default: begin
                pins.txrdy_n = !tx_empty;
                pins.rxrdy_n = rx_empty;
                rx_cond      = !rx_empty;
            end
        endcase
        pins.irq = (tx_irq_en && tx_empty) || (rx_irq_en && rx_cond);
    end

endmodule

// File: rtl/uart_ready_irq.sv
module uart_ready_irq
    import uart_rdy_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fifo_en,
    input  logic          dma_mode,
    input  logic [1:0]    rx_trig_sel,
    input  logic          tx_irq_en,
    input  logic          rx_irq_en,
    input  logic          cpu_wr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          cpu_rd,
    output logic [DW-1:0] cpu_rdata,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_data,
    input  logic          tx_pop,
    output logic [DW-1:0] tx_data,
    output logic          tx_avail,
    input  logic          char_timeout,
    output logic          txrdy_n,
    output logic          rxrdy_n,
    output logic          irq
);

    logic          en_q;
    logic          flush;
    fifo_ctl_t     tx_ctl;
    fifo_ctl_t     rx_ctl;
    logic [CW-1:0] tx_cnt;
    logic [CW-1:0] rx_cnt;
    logic [DW-1:0] rx_head;
    logic [CW-1:0] trig;
    logic          dma_act;
    rdy_mode_e     mode;
    pin_out_t      pins;

    // A change of the enable bit is seen for one cycle and empties both stores
    always_ff @(posedge clk) begin
        if (rst)
            en_q <= fifo_en;
        else
            en_q <= fifo_en;
    end
    assign flush = (fifo_en != en_q);

    assign mode   = pick_mode(fifo_en, dma_mode);
    assign trig   = CW'(trig_entries(rx_trig_sel));
    assign tx_ctl = '{push: cpu_wr,  pop: tx_pop, flush: flush};
    assign rx_ctl = '{push: rx_push, pop: cpu_rd, flush: flush};

    uart_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) i_tx_fifo (
        .clk    (clk),
        .rst    (rst),
        .ctl    (tx_ctl),
        .single (!fifo_en),
        .wdata  (cpu_wdata),
        .head   (tx_data),
        .count  (tx_cnt)
    );

    uart_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) i_rx_fifo (
        .clk    (clk),
        .rst    (rst),
        .ctl    (rx_ctl),
        .single (!fifo_en),
        .wdata  (rx_data),
        .head   (rx_head),
        .count  (rx_cnt)
    );

    uart_rx_dma_hyst #(.DEPTH(DEPTH)) i_rx_hyst (
        .clk     (clk),
        .rst     (rst),
        .enable  (fifo_en),
        .ctl     (rx_ctl),
        .count   (rx_cnt),
        .trig    (trig),
        .timeout (char_timeout),
        .active  (dma_act)
    );

    uart_pin_map #(.DEPTH(DEPTH)) i_pins (
        .mode      (mode),
        .tx_cnt    (tx_cnt),
        .rx_cnt    (rx_cnt),
        .trig      (trig),
        .dma_act   (dma_act),
        .tx_irq_en (tx_irq_en),
        .rx_irq_en (rx_irq_en),
        .pins      (pins)
    );

    always_ff @(posedge clk) begin
        if (rst)
            cpu_rdata <= '0;
        else if (cpu_rd && rx_cnt != '0 && !flush)
            cpu_rdata <= rx_head;
    end

    assign tx_avail = (tx_cnt != '0);
    assign txrdy_n  = pins.txrdy_n;
    assign rxrdy_n  = pins.rxrdy_n;
    assign irq      = pins.irq;

endmodule

// File: rtl/uart_ready_irq_chk.sv
module uart_ready_irq_chk #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          fifo_en,
    input logic          dma_mode,
    input logic          tx_irq_en,
    input logic          cpu_rd,
    input logic [DW-1:0] cpu_rdata,
    input logic          txrdy_n,
    input logic          rxrdy_n,
    input logic          irq,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt
);

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

    p_hold_single_r2: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en && !$past(fifo_en)) |-> (rx_cnt <= CW'(1)) && (tx_cnt <= CW'(1)));

    p_dma_keep_low_r6: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && dma_mode && $past(fifo_en) && $past(dma_mode)
         && !$past(rxrdy_n) && rx_cnt != '0) |-> !rxrdy_n);

    p_dma_release_r6: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && dma_mode && rx_cnt == '0) |-> rxrdy_n);

    p_dma_tx_free_r8: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && dma_mode && tx_cnt != CW'(DEPTH)) |-> !txrdy_n);

    p_tx_irq_r9: assert property (@(posedge clk) disable iff (rst)
        (tx_irq_en && tx_cnt == '0) |-> irq);

    p_rd_empty_r10: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && rx_cnt == '0) |=> $stable(cpu_rdata));

    p_flush_r11: assert property (@(posedge clk) disable iff (rst)
        (fifo_en != $past(fifo_en)) |=> (rx_cnt == '0) && (tx_cnt == '0));

endmodule

bind uart_ready_irq uart_ready_irq_chk #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .fifo_en   (fifo_en),
    .dma_mode  (dma_mode),
    .tx_irq_en (tx_irq_en),
    .cpu_rd    (cpu_rd),
    .cpu_rdata (cpu_rdata),
    .txrdy_n   (txrdy_n),
    .rxrdy_n   (rxrdy_n),
    .irq       (irq),
    .tx_cnt    (tx_cnt),
    .rx_cnt    (rx_cnt)
);

// File: tb/test_uart_ready_irq.sv
module test_uart_ready_irq;

    logic       clk = 1'b0;
    logic       rst;
    logic       fifo_en, dma_mode, tx_irq_en, rx_irq_en;
    logic [1:0] rx_trig_sel;
    logic       cpu_wr, cpu_rd, rx_push, tx_pop, char_timeout;
    logic [7:0] cpu_wdata, rx_data;
    logic [7:0] cpu_rdata, tx_data;
    logic       tx_avail, txrdy_n, rxrdy_n, irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    uart_ready_irq i_uart_ready_irq (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .dma_mode(dma_mode),
        .rx_trig_sel(rx_trig_sel), .tx_irq_en(tx_irq_en), .rx_irq_en(rx_irq_en),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
        .rx_push(rx_push), .rx_data(rx_data), .tx_pop(tx_pop), .tx_data(tx_data),
        .tx_avail(tx_avail), .char_timeout(char_timeout),
        .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n), .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int thr(input int code);
        case (code)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic rx_in(input logic [7:0] b);
        rx_push = 1'b1; rx_data = b;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic cpu_write(input logic [7:0] b);
        cpu_wr = 1'b1; cpu_wdata = b;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read();
        cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic tx_take();
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic set_mode(input logic en, input logic dma);
        fifo_en = en; dma_mode = dma;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1", "txrdy_n", txrdy_n, 1'b0);
        chk("R1", "rxrdy_n", rxrdy_n, 1'b1);
        chk("R1", "irq off", irq, 1'b0);
        chk("R1", "tx_avail", tx_avail, 1'b0);
        tx_irq_en = 1'b1;
        @(negedge clk);
        chk("R1", "irq follows tx_irq_en", irq, 1'b1);
        tx_irq_en = 1'b0;
    endtask

    task automatic t_hold();
        set_mode(1'b0, 1'b0);
        rx_irq_en = 1'b1;
        rx_in(8'hA1);
        chk("R2", "rxrdy_n held", rxrdy_n, 1'b0);
        chk("R9", "rx irq hold", irq, 1'b1);
        rx_in(8'hB2);
        cpu_read();
        chk("R2", "held byte", cpu_rdata, 8'hA1);
        chk("R2", "rxrdy_n empty", rxrdy_n, 1'b1);
        chk("R9", "rx irq clear", irq, 1'b0);
        rx_irq_en = 1'b0;
        cpu_write(8'h11);
        chk("R3", "txrdy_n held", txrdy_n, 1'b1);
        cpu_write(8'h22);
        chk("R3", "second write dropped", tx_data, 8'h11);
        tx_take();
        chk("R3", "txrdy_n empty", txrdy_n, 1'b0);
        chk("R3", "no extra byte", tx_avail, 1'b0);
    endtask

    task automatic t_fifo();
        set_mode(1'b1, 1'b0);
        rx_in(8'h10);
        chk("R4", "rxrdy_n one byte", rxrdy_n, 1'b0);
        rx_in(8'h20);
        rx_in(8'h30);
        cpu_read();
        chk("R12", "order 1", cpu_rdata, 8'h10);
        cpu_read();
        chk("R12", "order 2", cpu_rdata, 8'h20);
        chk("R4", "rxrdy_n one left", rxrdy_n, 1'b0);
        cpu_read();
        chk("R12", "order 3", cpu_rdata, 8'h30);
        chk("R4", "rxrdy_n empty", rxrdy_n, 1'b1);
        chk("R5", "txrdy_n empty", txrdy_n, 1'b0);
        cpu_write(8'h55);
        cpu_write(8'h66);
        chk("R5", "txrdy_n data", txrdy_n, 1'b1);
        chk("R12", "tx head", tx_data, 8'h55);
        tx_take();
        chk("R12", "tx next", tx_data, 8'h66);
        tx_take();
        chk("R5", "txrdy_n drained", txrdy_n, 1'b0);
    endtask

    task automatic t_dma_rx();
        set_mode(1'b1, 1'b1);
        rx_irq_en = 1'b1;
        for (int code = 0; code < 4; code++) begin
            int t;
            t = thr(code);
            rx_trig_sel = 2'(code);
            for (int i = 0; i < t - 1; i++) rx_in(8'(i));
            if (t > 1) begin
                chk("R6", "below trigger", rxrdy_n, 1'b1);
                chk("R9", "rx irq below trigger", irq, 1'b0);
            end
            rx_in(8'hF0);
            chk("R6", "at trigger", rxrdy_n, 1'b0);
            chk("R9", "rx irq at trigger", irq, 1'b1);
            for (int i = 0; i < t - 1; i++) begin
                cpu_read();
                chk("R6", "held low while draining", rxrdy_n, 1'b0);
            end
            cpu_read();
            chk("R6", "release on empty", rxrdy_n, 1'b1);
        end
        rx_irq_en = 1'b0;
    endtask

    task automatic t_dma_timeout();
        set_mode(1'b1, 1'b1);
        rx_trig_sel = 2'd3;
        rx_in(8'h01);
        rx_in(8'h02);
        chk("R7", "no request before timeout", rxrdy_n, 1'b1);
        char_timeout = 1'b1;
        @(negedge clk);
        char_timeout = 1'b0;
        chk("R7", "timeout request", rxrdy_n, 1'b0);
        cpu_read();
        chk("R7", "held after read", rxrdy_n, 1'b0);
        cpu_read();
        chk("R7", "released on empty", rxrdy_n, 1'b1);
        char_timeout = 1'b1;
        @(negedge clk);
        char_timeout = 1'b0;
        @(negedge clk);
        chk("R7", "timeout on empty ignored", rxrdy_n, 1'b1);
    endtask

    task automatic t_dma_tx();
        set_mode(1'b1, 1'b1);
        for (int i = 1; i <= 15; i++) cpu_write(8'(i));
        chk("R8", "one slot free", txrdy_n, 1'b0);
        cpu_write(8'd16);
        chk("R8", "full", txrdy_n, 1'b1);
        cpu_write(8'hEE);
        chk("R10", "write to full keeps full", txrdy_n, 1'b1);
        chk("R10", "head kept", tx_data, 8'd1);
        tx_take();
        chk("R8", "slot freed", txrdy_n, 1'b0);
        for (int i = 2; i <= 16; i++) begin
            chk("R10", "order after drop", tx_data, 32'(i));
            tx_take();
        end
        chk("R10", "dropped byte absent", tx_avail, 1'b0);
    endtask

    task automatic t_read_empty();
        logic [7:0] last;
        set_mode(1'b1, 1'b0);
        rx_in(8'h77);
        cpu_read();
        last = cpu_rdata;
        chk("R10", "setup read", last, 8'h77);
        cpu_read();
        chk("R10", "empty read keeps data", cpu_rdata, last);
        chk("R10", "empty read keeps count", rxrdy_n, 1'b1);
        rx_in(8'h88);
        cpu_read();
        chk("R10", "next byte after empty read", cpu_rdata, 8'h88);
        chk("R10", "count back to zero", rxrdy_n, 1'b1);
    endtask

    task automatic t_irq();
        set_mode(1'b1, 1'b0);
        tx_irq_en = 1'b1;
        @(negedge clk);
        chk("R9", "tx empty irq", irq, 1'b1);
        cpu_write(8'h42);
        chk("R9", "tx irq cleared", irq, 1'b0);
        rx_irq_en = 1'b1;
        rx_trig_sel = 2'd1;
        for (int i = 0; i < 3; i++) rx_in(8'(i));
        chk("R9", "rx below trigger", irq, 1'b0);
        rx_in(8'h03);
        chk("R9", "rx at trigger", irq, 1'b1);
        rx_irq_en = 1'b0;
        @(negedge clk);
        chk("R9", "rx term disabled", irq, 1'b0);
        tx_irq_en = 1'b0;
        set_mode(1'b0, 1'b0);
        set_mode(1'b1, 1'b0);
    endtask

    task automatic t_flush();
        set_mode(1'b1, 1'b1);
        rx_trig_sel = 2'd0;
        rx_in(8'hC1);
        rx_in(8'hC2);
        rx_in(8'hC3);
        cpu_write(8'hD1);
        cpu_write(8'hD2);
        chk("R11", "rx request before flush", rxrdy_n, 1'b0);
        fifo_en = 1'b0;
        @(negedge clk);
        chk("R11", "rxrdy_n after flush", rxrdy_n, 1'b1);
        chk("R11", "txrdy_n after flush", txrdy_n, 1'b0);
        chk("R11", "tx emptied", tx_avail, 1'b0);
        fifo_en = 1'b1;
        @(negedge clk);
        chk("R11", "dma latch cleared", rxrdy_n, 1'b1);
        rx_in(8'hE5);
        cpu_read();
        chk("R11", "no stale byte", cpu_rdata, 8'hE5);
        chk("R11", "empty after one read", rxrdy_n, 1'b1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1;
        fifo_en = 1'b0; dma_mode = 1'b0; rx_trig_sel = 2'd0;
        tx_irq_en = 1'b0; rx_irq_en = 1'b0;
        cpu_wr = 1'b0; cpu_rd = 1'b0; rx_push = 1'b0; tx_pop = 1'b0;
        char_timeout = 1'b0; cpu_wdata = '0; rx_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_hold();
        t_fifo();
        t_dma_rx();
        t_dma_timeout();
        t_dma_tx();
        t_read_empty();
        t_irq();
        t_flush();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule